// File: doc/BRIEF.md
# Floating-Point Exception Reporting Unit

This unit holds the control word and the status word of a stack-style floating-point engine. It also decides when and how an arithmetic exception reaches the rest of the chip. An execution stage reports one bit per exception class. The unit keeps those bits as sticky status flags and compares them against the mask bits in the control word. An unmasked flag is held as pending and is delivered only when a wait/serialise strobe arrives, which models asynchronous, deferred reporting.

Delivery takes one of two routes, chosen by the native-exception enable input. With the input high, the unit gives a one-cycle fault request to the core. With the input low, it drives a level error line toward an external interrupt controller. That line stays high until an init command clears the flags. The init command restores the power-on control word and clears the status word. A load port replaces the control word with a data operand. Entering or leaving the vector-alias mode leaves the control word untouched.

Top module: `fp_exc_unit`

## Requirements
- R1: After reset, and in the cycle after an `init` pulse, `ctrl_word` reads 0x037F and `fault_req` and `err_pin` are low. When `init` and `cw_load` occur in the same cycle, `init` takes priority.
- R2: In the cycle after `init`, `status_word` reads 0x0000.
- R3: Each bit of `exc_flags` sets the status flag at the same position. The bits are: 0 invalid operand or stack fault, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision. A flag is set whether it is masked or not, appears in `status_word[5:0]` one cycle later, and clears only on `init`.
- R4: `status_word[7]` is 1 exactly when some status flag is set and the control-word mask bit at the same position in `ctrl_word[5:0]` is 0. All other status bits read 0.
- R5: A `cw_load` pulse places `cw_data` into `ctrl_word` in the following cycle. For example, 0x037E unmasks invalid only, and 0x037A unmasks invalid and divide-by-zero.
- R6: While no `wait_strobe` arrives, a pending unmasked exception raises neither `fault_req` nor `err_pin`.
- R7: A `wait_strobe` while `status_word[7]` is 1 and `native_en` is 1 makes `fault_req` high for exactly the next cycle, and `err_pin` stays low.
- R8: A `wait_strobe` while `status_word[7]` is 1 and `native_en` is 0 sets `err_pin` from the next cycle. The pin holds until an `init` and is low in the cycle after that `init`.
- R9: An exception that arrives in the same cycle as a `wait_strobe` is not delivered by that strobe. It is delivered by the next strobe.
- R10: Loading a control word that unmasks a flag that is already set makes that flag pending (`status_word[7]` = 1). The next `wait_strobe` then delivers it.
- R11: `vec_enter` sets `vec_mode` and `vec_leave` clears it. Neither changes `ctrl_word`.
- R12: A `wait_strobe` with nothing pending raises neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Restore default control word, clear flags and outputs |
| exc_flags | input | 6 | Exception classes raised this cycle |
| cw_load | input | 1 | Load control word from `cw_data` |
| cw_data | input | 16 | Control-word operand |
| wait_strobe | input | 1 | Serialise: deliver any pending unmasked exception |
| native_en | input | 1 | 1 selects the internal fault, 0 selects the external pin |
| vec_enter | input | 1 | Enter vector-alias mode |
| vec_leave | input | 1 | Leave vector-alias mode |
| ctrl_word | output | 16 | Current control word |
| status_word | output | 16 | Flags in bits 5:0, summary in bit 7 |
| fault_req | output | 1 | One-cycle internal fault request |
| err_pin | output | 1 | Level error line toward an interrupt controller |
| vec_mode | output | 1 | Vector-alias mode active |

## Verification
The assertions check on every cycle the following:
- The fault request is a single-cycle pulse.
- Each delivery output rises only after a strobe taken on its own route.
- The error pin holds until init and drops after it.
- Flags never clear except by init.
- Mode changes never disturb the control word.

Only the bench scenarios can show:
- The exact reset and init values.
- The mapping of flags to status bits.
- The summary bit against particular masks such as 0x037E and 0x037A.
- That an exception arriving together with a strobe waits for the next strobe.
- That unmasking an old flag by a load makes it deliverable.

// File: rtl/fp_exc_unit.sv
module fp_exc_unit #(
  parameter int          NFLAG   = 6,
  parameter int          SUM_BIT = 7,
  parameter logic [15:0] CW_INIT = 16'h037F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [NFLAG-1:0] exc_flags,
  input  logic             cw_load,
  input  logic [15:0]      cw_data,
  input  logic             wait_strobe,
  input  logic             native_en,
  input  logic             vec_enter,
  input  logic             vec_leave,
  output logic [15:0]      ctrl_word,
  output logic [15:0]      status_word,
  output logic             fault_req,
  output logic             err_pin,
  output logic             vec_mode
);

  logic [15:0]      cw_q;
  logic [NFLAG-1:0] flags_q;
  logic             fault_q, err_q, vec_q;

  logic [NFLAG-1:0] unmasked;
  logic             summary;
  logic             deliver;

  assign unmasked = flags_q & ~cw_q[NFLAG-1:0];
  assign summary  = |unmasked;
  assign deliver  = wait_strobe & summary & ~init;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cw_q    <= CW_INIT;
      flags_q <= '0;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      if (init)         cw_q <= CW_INIT;
      else if (cw_load) cw_q <= cw_data;

      if (init) flags_q <= '0;
      else      flags_q <= flags_q | exc_flags;

      fault_q <= deliver & native_en;

      if (init)                       err_q <= 1'b0;
      else if (deliver && !native_en) err_q <= 1'b1;

      if (vec_enter)      vec_q <= 1'b1;
      else if (vec_leave) vec_q <= 1'b0;
    end
  end

  assign ctrl_word   = cw_q;
  assign status_word = 16'(flags_q) | (16'(summary) << SUM_BIT);
  assign fault_req   = fault_q;
  assign err_pin     = err_q;
  assign vec_mode    = vec_q;

endmodule

// File: rtl/fp_exc_unit_chk.sv
module fp_exc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init,
  input logic        cw_load,
  input logic        wait_strobe,
  input logic        native_en,
  input logic        vec_enter,
  input logic        vec_leave,
  input logic [15:0] ctrl_word,
  input logic [15:0] status_word,
  input logic        fault_req,
  input logic        err_pin
);

  p_init_cw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (ctrl_word == 16'h037F));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> ((status_word[5:0] & $past(status_word[5:0])) == $past(status_word[5:0])));

  p_fault_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> $past(wait_strobe && native_en));

  p_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pin) |-> $past(wait_strobe && !native_en));

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> !fault_req);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pin && !init) |=> err_pin);

  p_err_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!err_pin && !fault_req));

  p_vec_cw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_enter || vec_leave) && !cw_load && !init) |=> $stable(ctrl_word));

endmodule

bind fp_exc_unit fp_exc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .cw_load(cw_load),
  .wait_strobe(wait_strobe), .native_en(native_en),
  .vec_enter(vec_enter), .vec_leave(vec_leave),
  .ctrl_word(ctrl_word), .status_word(status_word),
  .fault_req(fault_req), .err_pin(err_pin)
);

// File: tb/test_fp_exc_unit.sv
module test_fp_exc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [5:0]  exc_flags = '0;
  logic        cw_load = 1'b0;
  logic [15:0] cw_data = '0;
  logic        wait_strobe = 1'b0;
  logic        native_en = 1'b1;
  logic        vec_enter = 1'b0;
  logic        vec_leave = 1'b0;
  logic [15:0] ctrl_word, status_word;
  logic        fault_req, err_pin, vec_mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_exc_unit i_fp_exc_unit (
    .clk(clk), .rst_n(rst_n), .init(init), .exc_flags(exc_flags),
    .cw_load(cw_load), .cw_data(cw_data), .wait_strobe(wait_strobe),
    .native_en(native_en), .vec_enter(vec_enter), .vec_leave(vec_leave),
    .ctrl_word(ctrl_word), .status_word(status_word),
    .fault_req(fault_req), .err_pin(err_pin), .vec_mode(vec_mode)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    init = 1'b0; exc_flags = '0; cw_load = 1'b0; wait_strobe = 1'b0;
    vec_enter = 1'b0; vec_leave = 1'b0;
  endtask

  task automatic do_init();
    init = 1'b1; tick();
  endtask

  task automatic load_cw(input logic [15:0] v);
    cw_load = 1'b1; cw_data = v; tick();
  endtask

  task automatic t_reset();
    chk("R1 reset cw", ctrl_word, 16'h037F);
    chk("R1 reset fault", 16'(fault_req), 16'h0);
    chk("R1 reset err", 16'(err_pin), 16'h0);
    chk("R2 reset status", status_word, 16'h0000);
  endtask

  task automatic t_sticky();
    do_init();
    exc_flags = 6'b100010; tick();
    chk("R3 flags set masked", status_word, 16'h0022);
    exc_flags = 6'b001000; tick();
    chk("R3 flags accumulate", status_word, 16'h002A);
    tick(); tick();
    chk("R3 flags sticky", status_word, 16'h002A);
    do_init();
    chk("R2 status after init", status_word, 16'h0000);
    chk("R1 cw after init", ctrl_word, 16'h037F);
  endtask

  task automatic t_summary();
    do_init();
    load_cw(16'h037E);
    chk("R5 load 037E", ctrl_word, 16'h037E);
    exc_flags = 6'b000100; tick();
    chk("R4 zdiv masked no summary", status_word, 16'h0004);
    exc_flags = 6'b000001; tick();
    chk("R4 invalid unmasked summary", status_word, 16'h0085);
    for (int i = 0; i < 3; i++) tick();
    chk("R6 no fault without wait", 16'(fault_req), 16'h0);
    chk("R6 no err without wait", 16'(err_pin), 16'h0);
  endtask

  task automatic t_native();
    native_en = 1'b1;
    wait_strobe = 1'b1; tick();
    chk("R7 fault pulse", 16'(fault_req), 16'h1);
    chk("R7 err low", 16'(err_pin), 16'h0);
    tick();
    chk("R7 fault one cycle", 16'(fault_req), 16'h0);
  endtask

  task automatic t_legacy();
    native_en = 1'b0;
    wait_strobe = 1'b1; tick();
    chk("R8 err set", 16'(err_pin), 16'h1);
    chk("R8 no fault", 16'(fault_req), 16'h0);
    for (int i = 0; i < 4; i++) tick();
    chk("R8 err holds", 16'(err_pin), 16'h1);
    do_init();
    chk("R8 err drops after init", 16'(err_pin), 16'h0);
    native_en = 1'b1;
  endtask

  task automatic t_same_cycle();
    do_init();
    load_cw(16'h037E);
    exc_flags = 6'b000001; wait_strobe = 1'b1; tick();
    chk("R9 not delivered same cycle", 16'(fault_req), 16'h0);
    chk("R9 flag pending", status_word, 16'h0081);
    wait_strobe = 1'b1; tick();
    chk("R9 delivered next wait", 16'(fault_req), 16'h1);
  endtask

  task automatic t_unmask();
    do_init();
    exc_flags = 6'b000100; tick();
    wait_strobe = 1'b1; tick();
    chk("R12 masked wait no fault", 16'(fault_req), 16'h0);
    load_cw(16'h037A);
    chk("R10 unmask makes pending", status_word, 16'h0084);
    wait_strobe = 1'b1; tick();
    chk("R10 delivered after unmask", 16'(fault_req), 16'h1);
  endtask

  task automatic t_idle();
    do_init();
    native_en = 1'b0;
    wait_strobe = 1'b1; tick();
    chk("R12 idle wait no err", 16'(err_pin), 16'h0);
    chk("R12 idle wait no fault", 16'(fault_req), 16'h0);
    native_en = 1'b1;
  endtask

  task automatic t_priority();
    init = 1'b1; cw_load = 1'b1; cw_data = 16'h1234; tick();
    chk("R1 init beats load", ctrl_word, 16'h037F);
  endtask

  task automatic t_vector();
    load_cw(16'h037A);
    vec_enter = 1'b1; tick();
    chk("R11 vec on", 16'(vec_mode), 16'h1);
    chk("R11 cw kept on enter", ctrl_word, 16'h037A);
    vec_leave = 1'b1; tick();
    chk("R11 vec off", 16'(vec_mode), 16'h0);
    chk("R11 cw kept on leave", ctrl_word, 16'h037A);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sticky();
    t_summary();
    t_native();
    t_legacy();
    t_same_cycle();
    t_unmask();
    t_idle();
    t_priority();
    t_vector();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule